// File: doc/BRIEF.md
# ADC Sample Octet Packer

This block turns one frame of converter samples into the octet stream of a serial link's transport layer. Each frame carries one 14-bit sample from every converter. Each sample is widened to a 16-bit word: the sample fills the top fourteen bits and two low bits are filled from a selectable source. The word then leaves as two octets, most significant first. Converter 0 goes first, then converter 1, and so on up to the last one.

A frame is taken when `in_valid` is high and the packer is idle or is emitting the last octet of the current frame. The packer captures the samples, the per-converter flags, the tail mode and the control-bit selection in that cycle. It then emits 2×M octets on consecutive cycles, with a marker on the first octet of converter 0. A new frame accepted on the last-octet cycle follows without a gap, so a source that presents a frame every 2×M cycles gets a continuous stream. Scrambling, line coding and serialization belong to later stages.

Top module: `adc_octet_packer`

## Requirements
- R1: While reset is applied and on the cycle after it, `out_valid`, `out_frame_start` and `out_octet` are all zero.
- R2: The first octet of each word equals sample bits 13 down to 6.
- R3: Bits 7..2 of the second octet of each word equal sample bits 5 down to 0.
- R4: Bits 1..0 of the second octet, called the tail, are zero when the captured tail mode is 2'b00 or 2'b11.
- R5: With tail mode 2'b01 the tail equals bits 1..0 of a 9-bit LFSR. The LFSR uses the feedback x^9+x^5+1 (new bit = q[8]^q[4], shifted in at bit 0) and is set to all ones by reset. It steps once at the end of every emitted word, whatever the mode, and is never reloaded between frames.
- R6: With tail mode 2'b10, tail bit 1 is the converter's overrange flag. Tail bit 0 is the converter's fast-detect flag when `ctrl_low_sel` is 0, and the shared SYSREF-seen flag when it is 1.
- R7: Words leave in converter order 0 to M−1, and the two octets of each word are adjacent. Converter n's sample is `in_samples[n*14 +: 14]`.
- R8: Each accepted frame gives exactly 2×M cycles of `out_valid`. They start on the cycle after the accept cycle, and `out_valid` is never high without an accepted frame.
- R9: `out_frame_start` is high only together with the first octet of converter 0 of each frame.
- R10: An `in_valid` pulse during any emission cycle other than a frame's last octet is ignored. A pulse during the last octet is accepted, so the next frame follows with no idle cycle.
- R11: Samples, flags, tail mode and control-bit selection are captured in the accept cycle. Later changes to these inputs do not alter the frame being emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame offer strobe |
| in_samples | input | NUM_CONV*14 | Converter samples, converter n at bits n*14 upward |
| in_overrange | input | NUM_CONV | Per-converter overrange flag |
| in_fast_detect | input | NUM_CONV | Per-converter threshold (fast detect) flag |
| in_sysref_seen | input | 1 | Flag that the system reference edge was seen |
| tail_mode | input | 2 | Tail source: 00 zero, 01 pseudorandom, 10 control flags, 11 zero |
| ctrl_low_sel | input | 1 | In control mode, tail bit 0 carries fast detect (0) or SYSREF-seen (1) |
| out_valid | output | 1 | Octet valid |
| out_frame_start | output | 1 | First octet of converter 0 of a frame |
| out_octet | output | 8 | Transport octet |

## Verification
The bench uses the default parameters: two converters, 14-bit samples and 8-bit octets, so each frame is four octets. The configuration is small enough to sweep every 14-bit code through converter 0 in back-to-back frames, with a complementary pattern on converter 1. The bench also walks every combination of the two overrange flags, the two fast-detect flags, the SYSREF-seen flag and the low-bit selection in control mode. A bench model of the 9-bit LFSR predicts the pseudorandom tails across frames. Junk on the inputs between accepts, and a strobe in the middle of a frame, show that captured frames are not altered and that mid-frame offers are dropped.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;

  typedef enum logic [1:0] {
    TAIL_ZERO = 2'b00,
    TAIL_PRN  = 2'b01,
    TAIL_CTRL = 2'b10,
    TAIL_RSVD = 2'b11
  } tail_mode_e;

endpackage

// File: rtl/packer_lfsr.sv
module packer_lfsr #(
  parameter int W   = 9,
  parameter int TAP = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);

  // Fibonacci form: top bit XOR tap bit enters at bit 0
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '1;
    end else if (step) begin
      state <= {state[W-2:0], state[W-1] ^ state[TAP-1]};
    end
  end

endmodule

// File: rtl/packer_seq.sv
module packer_seq #(
  parameter int NUM_CONV = 2,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             accept,
  output logic             active,
  output logic             last,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2 * NUM_CONV - 1);

  assign last   = active && (idx == LAST_IDX);
  assign accept = in_valid && (!active || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (last) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/packer_word.sv
module packer_word
  import adc_pack_pkg::*;
#(
  parameter int NUM_CONV = 2,
  parameter int SAMPLE_W = 14,
  parameter int OCTET_W  = 8,
  parameter int CONV_W   = 1,
  parameter int PRN_W    = 9
) (
  input  logic [NUM_CONV-1:0][SAMPLE_W-1:0] smp,
  input  logic [NUM_CONV-1:0]               ovr,
  input  logic [NUM_CONV-1:0]               fdet,
  input  logic                              sysref,
  input  tail_mode_e                        mode,
  input  logic                              low_sel,
  input  logic [CONV_W-1:0]                 conv,
  input  logic [PRN_W-1:0]                  prn,
  output logic [2*OCTET_W-1:0]              word
);

  localparam int TAIL_W = 2 * OCTET_W - SAMPLE_W;

  logic [TAIL_W-1:0] tail;
  logic              low_flag;

  always_comb begin
    low_flag = low_sel ? sysref : fdet[conv];
    case (mode)
      TAIL_PRN:  tail = prn[TAIL_W-1:0];
      TAIL_CTRL: tail = TAIL_W'({ovr[conv], low_flag});
      default:   tail = '0;
    endcase
    word = {smp[conv], tail};
  end

endmodule

// File: rtl/adc_octet_packer.sv
module adc_octet_packer
  import adc_pack_pkg::*;
#(
  parameter int NUM_CONV = 2,
  parameter int SAMPLE_W = 14,
  parameter int OCTET_W  = 8,
  parameter int PRN_W    = 9,
  parameter int PRN_TAP  = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [NUM_CONV*SAMPLE_W-1:0] in_samples,
  input  logic [NUM_CONV-1:0]          in_overrange,
  input  logic [NUM_CONV-1:0]          in_fast_detect,
  input  logic                         in_sysref_seen,
  input  logic [1:0]                   tail_mode,
  input  logic                         ctrl_low_sel,
  output logic                         out_valid,
  output logic                         out_frame_start,
  output logic [OCTET_W-1:0]           out_octet
);

  localparam int CONV_W = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1;
  localparam int IDX_W  = CONV_W + 1;
  localparam int WORD_W = 2 * OCTET_W;

  logic             accept, active, last;
  logic [IDX_W-1:0] idx;

  packer_seq #(.NUM_CONV(NUM_CONV), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .accept(accept), .active(active), .last(last), .idx(idx)
  );

  // Frame capture, one slice per converter
  logic [NUM_CONV-1:0][SAMPLE_W-1:0] frm_smp;
  logic [NUM_CONV-1:0]               frm_ovr;
  logic [NUM_CONV-1:0]               frm_fdet;

  for (genvar n = 0; n < NUM_CONV; n++) begin : g_conv
    always_ff @(posedge clk) begin
      if (rst) begin
        frm_smp[n]  <= '0;
        frm_ovr[n]  <= 1'b0;
        frm_fdet[n] <= 1'b0;
      end else if (accept) begin
        frm_smp[n]  <= in_samples[n*SAMPLE_W +: SAMPLE_W];
        frm_ovr[n]  <= in_overrange[n];
        frm_fdet[n] <= in_fast_detect[n];
      end
    end
  end

  logic       frm_sysref;
  logic       frm_low_sel;
  tail_mode_e frm_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_sysref  <= 1'b0;
      frm_low_sel <= 1'b0;
      frm_mode    <= TAIL_ZERO;
    end else if (accept) begin
      frm_sysref  <= in_sysref_seen;
      frm_low_sel <= ctrl_low_sel;
      frm_mode    <= tail_mode_e'(tail_mode);
    end
  end

  // Pseudorandom tail source steps at the end of each word
  logic [PRN_W-1:0] prn;

  packer_lfsr #(.W(PRN_W), .TAP(PRN_TAP)) u_prn (
    .clk(clk), .rst(rst), .step(active && idx[0]), .state(prn)
  );

  logic [WORD_W-1:0] word;

  packer_word #(
    .NUM_CONV(NUM_CONV), .SAMPLE_W(SAMPLE_W), .OCTET_W(OCTET_W),
    .CONV_W(CONV_W), .PRN_W(PRN_W)
  ) u_word (
    .smp(frm_smp), .ovr(frm_ovr), .fdet(frm_fdet), .sysref(frm_sysref),
    .mode(frm_mode), .low_sel(frm_low_sel), .conv(idx[IDX_W-1:1]),
    .prn(prn), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_frame_start <= 1'b0;
      out_octet       <= '0;
    end else begin
      out_valid       <= active;
      out_frame_start <= active && (idx == '0);
      if (!active) begin
        out_octet <= '0;
      end else if (idx[0]) begin
        out_octet <= word[OCTET_W-1:0];
      end else begin
        out_octet <= word[WORD_W-1:OCTET_W];
      end
    end
  end

endmodule

// File: rtl/adc_octet_packer_chk.sv
module adc_octet_packer_chk #(
  parameter int NUM_CONV = 2
) (
  input logic clk,
  input logic rst,
  input logic out_valid,
  input logic out_frame_start
);

  localparam int RUN_MAX = 2 * NUM_CONV;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(RUN_MAX);

  // Octets seen so far in the current frame
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
    end else if (out_valid) begin
      run <= out_frame_start ? RUN_W'(1) : run + 1'b1;
    end else begin
      run <= '0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_frame_start));

  // R9
  start_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_frame_start |-> out_valid);

  // R8
  run_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_frame_start) |-> (run != '0 && run < RUN_FULL));

  // R9
  start_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    out_frame_start |-> (run == '0 || run == RUN_FULL));

  // R8
  gap_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (run == '0 || run == RUN_FULL));

endmodule

bind adc_octet_packer adc_octet_packer_chk #(.NUM_CONV(NUM_CONV)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_frame_start(out_frame_start)
);

// File: tb/adc_octet_packer_bench.sv
`timescale 1ns/1ps
module adc_octet_packer_bench;

  localparam int M  = 2;
  localparam int SW = 14;
  localparam int OW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst;
  logic            in_valid;
  logic [M*SW-1:0] in_samples;
  logic [M-1:0]    in_overrange, in_fast_detect;
  logic            in_sysref_seen;
  logic [1:0]      tail_mode;
  logic            ctrl_low_sel;
  logic            out_valid, out_frame_start;
  logic [OW-1:0]   out_octet;

  adc_octet_packer #(.NUM_CONV(M)) u_adc_octet_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
    .in_overrange(in_overrange), .in_fast_detect(in_fast_detect),
    .in_sysref_seen(in_sysref_seen), .tail_mode(tail_mode),
    .ctrl_low_sel(ctrl_low_sel), .out_valid(out_valid),
    .out_frame_start(out_frame_start), .out_octet(out_octet)
  );

  int checks = 0;
  int errors = 0;
  int sent_frames = 0;
  int total_oct = 0;
  bit done = 0;

  // entry: {mode[1:0], sel, sysref, fdet, ovr, sample[13:0]}
  logic [19:0] expq[$];
  logic [8:0]  lf = 9'h1FF;
  int          half = 0;
  int          word_in_frame = 0;
  logic [19:0] e;
  logic [1:0]  tl;
  string       tag;

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      total_oct++;
      if (expq.size() == 0) begin
        chk(1'b0, "R8 octet without an accepted frame", int'(out_octet), 0);
      end else begin
        e = expq[0];
        if (half == 0) begin
          chk(out_octet == e[13:6], "R2 R7 high octet", int'(out_octet), int'(e[13:6]));
          chk(out_frame_start == (word_in_frame == 0), "R9 frame start on high octet",
              int'(out_frame_start), int'(word_in_frame == 0));
          half = 1;
        end else begin
          case (e[19:18])
            2'b01: begin tl = lf[1:0]; tag = "R3 R5 low octet prn tail"; end
            2'b10: begin tl = {e[14], e[17] ? e[16] : e[15]}; tag = "R3 R6 low octet ctrl tail"; end
            default: begin tl = 2'b00; tag = "R3 R4 low octet zero tail"; end
          endcase
          chk(out_octet == {e[5:0], tl}, tag, int'(out_octet), int'({e[5:0], tl}));
          chk(out_frame_start == 1'b0, "R9 no start on low octet", int'(out_frame_start), 0);
          lf = {lf[7:0], lf[8] ^ lf[4]};
          void'(expq.pop_front());
          half = 0;
          word_in_frame = (word_in_frame + 1) % M;
        end
      end
    end
  end

  // Offer a frame at posedge+1, then wait gap further edges; junk follows the accept (R11)
  task automatic send(input logic [SW-1:0] s0, input logic [SW-1:0] s1,
                      input logic [1:0] ov, input logic [1:0] fd, input logic sr,
                      input logic [1:0] md, input logic sl, input int gap);
    in_samples     = {s1, s0};
    in_overrange   = ov;
    in_fast_detect = fd;
    in_sysref_seen = sr;
    tail_mode      = md;
    ctrl_low_sel   = sl;
    in_valid       = 1'b1;
    expq.push_back({md, sl, sr, fd[0], ov[0], s0});
    expq.push_back({md, sl, sr, fd[1], ov[1], s1});
    sent_frames++;
    @(posedge clk);
    #1;
    in_valid       = 1'b0;
    in_samples     = (M*SW)'($urandom);
    in_overrange   = 2'($urandom);
    in_fast_detect = 2'($urandom);
    in_sysref_seen = 1'($urandom);
    tail_mode      = 2'($urandom);
    ctrl_low_sel   = 1'($urandom);
    repeat (gap) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_samples = '0; in_overrange = '0;
    in_fast_detect = '0; in_sysref_seen = 1'b0; tail_mode = 2'b00; ctrl_low_sel = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    chk(out_frame_start == 1'b0, "R1 start after reset", int'(out_frame_start), 0);
    chk(out_octet == '0, "R1 octet after reset", int'(out_octet), 0);
    @(posedge clk);
    #1;

    // R2 R3 R4 R7 R10: every code on converter 0, back-to-back frames
    for (int v = 0; v < (1 << SW); v++) begin
      send(SW'(v), SW'(v) ^ 14'h2AAA, 2'b11, 2'b11, 1'b1, 2'b00, 1'b1, 2 * M - 1);
    end
    // R5: pseudorandom tails with idle gaps between frames
    for (int i = 0; i < 64; i++) begin
      send(SW'($urandom), SW'($urandom), 2'b00, 2'b00, 1'b0, 2'b01, 1'b0,
           (i % 3 == 0) ? 7 : 2 * M - 1);
    end
    // R6: every flag and selection combination
    for (int c = 0; c < 64; c++) begin
      send(SW'($urandom), SW'($urandom), 2'(c), 2'(c >> 2), 1'(c >> 4), 2'b10,
           1'(c >> 5), 2 * M - 1);
    end
    // R4: reserved mode acts as zeros
    for (int i = 0; i < 16; i++) begin
      send(SW'($urandom), SW'($urandom), 2'b11, 2'b11, 1'b1, 2'b11, 1'(i), 2 * M - 1);
    end
    repeat (6) @(posedge clk);
    #1;
    chk(total_oct == sent_frames * 2 * M, "R8 octet count after sweeps",
        total_oct, sent_frames * 2 * M);

    // R10: offer in the middle of a frame is dropped
    send(14'h1234, 14'h0ABC, 2'b01, 2'b10, 1'b0, 2'b10, 1'b0, 1);
    in_samples = {14'h3FFF, 14'h3FFF};
    tail_mode  = 2'b01;
    in_valid   = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    chk(total_oct == sent_frames * 2 * M, "R10 mid-frame offer ignored",
        total_oct, sent_frames * 2 * M);
    chk(expq.size() == 0, "R11 all captured frames emitted", expq.size(), 0);
    chk(out_valid == 1'b0, "R8 idle after last frame", int'(out_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule